// File: doc/BRIEF.md
# Bidirectional Logarithmic Logical Shifter

This block shifts a data word left or right by a variable amount in one combinational pass, with zero fill and no rotation. A single shared right-shift network of log-weighted stages does all the work. For a left shift the word is mirrored (bit j swapped with bit W-1-j) before the network and mirrored back after it. Both mirror units are idle when the direction requests a right shift.

Every stage is assembled from three reversible primitives:
- a controlled swap used as a 2:1 selector;
- a copy gate that gives each data bit a second fan-out;
- an AND-style gate that forces zero into the positions a shift vacates.

Each primitive has outputs the data path does not use. These are collected and exposed on a side port so that the reversible structure stays observable. Typical use is operand alignment and normalization in floating-point datapaths.

Top module: `rls_shifter`

## Requirements
- R1: With `dirLeft` = 0, `dataOut` equals `dataIn` shifted toward bit 0 by `shiftAmt` places, and the top `shiftAmt` bits of `dataOut` are 0.
- R2: With `dirLeft` = 1, `dataOut` equals `dataIn` shifted toward the MSB by `shiftAmt` places, and the low `shiftAmt` bits of `dataOut` are 0.
- R3: With `shiftAmt` = 0, `dataOut` equals `dataIn` for either direction.
- R4: Bits shifted past either end are discarded, never wrapped. The number of ones in `dataOut` never exceeds the number in `dataIn`.
- R5: An all-zero `dataIn` gives an all-zero `dataOut` for every amount and direction.
- R6: `junkOut` bits [2*(DATA_W/2)-1:0] carry the control pass-through of the two mirror units, so every one of those bits equals `dirLeft`.
- R7: For DATA_W=4 and AMT_W=2, with input {m3,m2,m1,m0}, the outputs are as follows:
  - right shifts by 1, 2 and 3 give {0,m3,m2,m1}, {0,0,m3,m2} and {0,0,0,m3};
  - left shifts by 1, 2 and 3 give {m2,m1,m0,0}, {m1,m0,0,0} and {m0,0,0,0}.
- R8: A left shift of x equals the mirror of a right shift of the mirror of x, by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataIn | input | DATA_W | Word to shift |
| shiftAmt | input | AMT_W | Shift distance; bit i enables the stage moving by 2^i |
| dirLeft | input | 1 | 0 = logical right, 1 = logical left |
| dataOut | output | DATA_W | Shifted word |
| junkOut | output | 2*(DATA_W/2)+AMT_W*2*DATA_W | Unused primitive outputs; mirror units in the low bits, then stages 0 upward |

## Verification
Both the 8-bit/3-stage and the 4-bit/2-stage builds are swept over every data value, amount and direction. This tells a wrong stage weight apart from a wrong fill value or a swapped direction. Named-bit 4-bit patterns pin each output position to a specific input bit, which exposes a mirror unit that crosses the wrong pair. Random words paired with their mirrors compare left shifts against mirrored right shifts. All-ones words and zero words separate wrap-around from lost bits.

// File: rtl/rls_pkg.sv
package rls_pkg;

  // Direction strobes handed from control to datapath
  typedef struct packed {
    logic mirrorIn;   // mirror the word before the right-shift core
    logic mirrorOut;  // mirror the word after the right-shift core
  } dir_strobe_t;

endpackage

// File: rtl/rls_gates.sv
// Controlled swap: when ctl is 1 the two data lines exchange.
module rls_swap_gate (
  input  logic ctl,
  input  logic aIn,
  input  logic bIn,
  output logic pOut,
  output logic qOut,
  output logic rOut
);
  always_comb begin
    pOut = ctl;
    qOut = ctl ? bIn : aIn;
    rOut = ctl ? aIn : bIn;
  end
endmodule

// Copy gate: target XOR source; with a zero target both outputs copy the source.
module rls_copy_gate (
  input  logic aIn,
  input  logic tgtIn,
  output logic pOut,
  output logic qOut
);
  always_comb begin
    pOut = aIn;
    qOut = aIn ^ tgtIn;
  end
endmodule

// AND-style gate: third output is (a AND b) XOR target.
module rls_and_gate (
  input  logic aIn,
  input  logic bIn,
  input  logic tgtIn,
  output logic pOut,
  output logic qOut,
  output logic rOut
);
  always_comb begin
    pOut = aIn;
    qOut = aIn ^ bIn;
    rOut = (aIn & bIn) ^ tgtIn;
  end
endmodule

// File: rtl/rls_mirror.sv
module rls_mirror #(
  parameter int WIDTH = 8,
  localparam int HALF = WIDTH / 2
) (
  input  logic             ctl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [HALF-1:0]  junk
);
  genvar j;
  generate
    for (j = 0; j < HALF; j++) begin : g_pair
      rls_swap_gate u_swap (
        .ctl (ctl),
        .aIn (din[j]),
        .bIn (din[WIDTH-1-j]),
        .pOut(junk[j]),
        .qOut(dout[j]),
        .rOut(dout[WIDTH-1-j])
      );
    end
    if (WIDTH % 2 == 1) begin : g_mid
      assign dout[HALF] = din[HALF];
    end
  endgenerate
endmodule

// File: rtl/rls_stage.sv
module rls_stage #(
  parameter int WIDTH = 8,
  parameter int STEP  = 1,
  localparam int LANES = WIDTH - STEP
) (
  input  logic               go,
  input  logic               hold,
  input  logic [WIDTH-1:0]   din,
  output logic [WIDTH-1:0]   dout,
  output logic [2*WIDTH-1:0] junk
);
  logic [WIDTH-1:0]    keepBit;
  logic [WIDTH-1:STEP] fwdBit;

  genvar j;
  generate
    // fan-out: bits that also feed a lower lane get a copy
    for (j = 0; j < WIDTH; j++) begin : g_fan
      if (j >= STEP) begin : g_copy
        rls_copy_gate u_copy (
          .aIn  (din[j]),
          .tgtIn(1'b0),
          .pOut (keepBit[j]),
          .qOut (fwdBit[j])
        );
      end else begin : g_direct
        assign keepBit[j] = din[j];
      end
    end
    // lanes that can receive a shifted bit use a selector
    for (j = 0; j < LANES; j++) begin : g_sel
      rls_swap_gate u_sel (
        .ctl (go),
        .aIn (keepBit[j]),
        .bIn (fwdBit[j+STEP]),
        .pOut(junk[2*j]),
        .qOut(dout[j]),
        .rOut(junk[2*j+1])
      );
    end
    // top lanes only keep or clear
    for (j = LANES; j < WIDTH; j++) begin : g_fill
      rls_and_gate u_and (
        .aIn  (keepBit[j]),
        .bIn  (hold),
        .tgtIn(1'b0),
        .pOut (junk[2*j]),
        .qOut (junk[2*j+1]),
        .rOut (dout[j])
      );
    end
  endgenerate
endmodule

// File: rtl/rls_ctrl.sv
module rls_ctrl #(
  parameter int AMT_W = 3
) (
  input  logic                 dirLeft,
  input  logic [AMT_W-1:0]     shiftAmt,
  output rls_pkg::dir_strobe_t dirStb,
  output logic [AMT_W-1:0]     stageGo,
  output logic [AMT_W-1:0]     stageHold
);
  always_comb begin
    dirStb.mirrorIn  = dirLeft;
    dirStb.mirrorOut = dirLeft;
    stageGo          = shiftAmt;
    stageHold        = ~shiftAmt;
  end
endmodule

// File: rtl/rls_datapath.sv
module rls_datapath #(
  parameter int DATA_W = 8,
  parameter int AMT_W  = 3,
  localparam int HALF   = DATA_W / 2,
  localparam int STG_J  = 2 * DATA_W,
  localparam int JUNK_W = 2 * HALF + AMT_W * STG_J
) (
  input  rls_pkg::dir_strobe_t dirStb,
  input  logic [AMT_W-1:0]     stageGo,
  input  logic [AMT_W-1:0]     stageHold,
  input  logic [DATA_W-1:0]    dataIn,
  output logic [DATA_W-1:0]    dataOut,
  output logic [JUNK_W-1:0]    junkOut
);
  logic [DATA_W-1:0]      stageData [AMT_W+1];
  logic [AMT_W*STG_J-1:0] stageJunk;
  logic [HALF-1:0]        inJunk;
  logic [HALF-1:0]        outJunk;

  rls_mirror #(.WIDTH(DATA_W)) u_mirrorIn (
    .ctl (dirStb.mirrorIn),
    .din (dataIn),
    .dout(stageData[0]),
    .junk(inJunk)
  );

  genvar i;
  generate
    for (i = 0; i < AMT_W; i++) begin : g_stage
      rls_stage #(.WIDTH(DATA_W), .STEP(1 << i)) u_stage (
        .go  (stageGo[i]),
        .hold(stageHold[i]),
        .din (stageData[i]),
        .dout(stageData[i+1]),
        .junk(stageJunk[i*STG_J +: STG_J])
      );
    end
  endgenerate

  rls_mirror #(.WIDTH(DATA_W)) u_mirrorOut (
    .ctl (dirStb.mirrorOut),
    .din (stageData[AMT_W]),
    .dout(dataOut),
    .junk(outJunk)
  );

  assign junkOut = {stageJunk, outJunk, inJunk};
endmodule

// File: rtl/rls_shifter.sv
module rls_shifter #(
  parameter int DATA_W = 8,
  parameter int AMT_W  = 3,
  localparam int HALF   = DATA_W / 2,
  localparam int JUNK_W = 2 * HALF + AMT_W * 2 * DATA_W
) (
  input  logic [DATA_W-1:0] dataIn,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic              dirLeft,
  output logic [DATA_W-1:0] dataOut,
  output logic [JUNK_W-1:0] junkOut
);
  rls_pkg::dir_strobe_t dirStb;
  logic [AMT_W-1:0]     stageGo;
  logic [AMT_W-1:0]     stageHold;

  rls_ctrl #(.AMT_W(AMT_W)) u_ctrl (
    .dirLeft  (dirLeft),
    .shiftAmt (shiftAmt),
    .dirStb   (dirStb),
    .stageGo  (stageGo),
    .stageHold(stageHold)
  );

  rls_datapath #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dp (
    .dirStb   (dirStb),
    .stageGo  (stageGo),
    .stageHold(stageHold),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .junkOut  (junkOut)
  );
endmodule

// File: rtl/rls_shifter_checker.sv
module rls_shifter_checker #(
  parameter int DATA_W = 8,
  parameter int AMT_W  = 3,
  localparam int HALF   = DATA_W / 2,
  localparam int JUNK_W = 2 * HALF + AMT_W * 2 * DATA_W
) (
  input logic [DATA_W-1:0] dataIn,
  input logic [AMT_W-1:0]  shiftAmt,
  input logic              dirLeft,
  input logic [DATA_W-1:0] dataOut,
  input logic [JUNK_W-1:0] junkOut
);
  always_comb begin
    AST_RIGHT_SHIFT: assert (dirLeft || dataOut == (dataIn >> shiftAmt))
      else $error("right shift mismatch"); // R1
    AST_LEFT_SHIFT: assert (!dirLeft || dataOut == (dataIn << shiftAmt))
      else $error("left shift mismatch"); // R2
    AST_ZERO_AMT_PASS: assert (shiftAmt != '0 || dataOut == dataIn)
      else $error("zero amount altered data"); // R3
    AST_NO_WRAP: assert ($countones(dataOut) <= $countones(dataIn))
      else $error("ones appeared in output"); // R4
    AST_ZERO_IN: assert (dataIn != '0 || dataOut == '0)
      else $error("zero input gave nonzero output"); // R5
    AST_MIRROR_JUNK: assert (junkOut[2*HALF-1:0] == {(2*HALF){dirLeft}})
      else $error("mirror control junk mismatch"); // R6
  end
endmodule

bind rls_shifter rls_shifter_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .dataIn  (dataIn),
  .shiftAmt(shiftAmt),
  .dirLeft (dirLeft),
  .dataOut (dataOut),
  .junkOut (junkOut)
);

// File: tb/rls_shifter_bench.sv
module rls_shifter_bench;
  localparam int W8 = 8, A8 = 3, J8 = 8 + 3 * 16;
  localparam int W4 = 4, A4 = 2, J4 = 4 + 2 * 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [W8-1:0] d8 = '0;
  logic [A8-1:0] a8 = '0;
  logic          l8 = 1'b0;
  logic [W8-1:0] o8;
  logic [J8-1:0] j8;
  logic [W4-1:0] d4 = '0;
  logic [A4-1:0] a4 = '0;
  logic          l4 = 1'b0;
  logic [W4-1:0] o4;
  logic [J4-1:0] j4;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  rls_shifter #(.DATA_W(W8), .AMT_W(A8)) u_rls_shifter (
    .dataIn(d8), .shiftAmt(a8), .dirLeft(l8), .dataOut(o8), .junkOut(j8));
  rls_shifter #(.DATA_W(W4), .AMT_W(A4)) u_rls_shifter_n4 (
    .dataIn(d4), .shiftAmt(a4), .dirLeft(l4), .dataOut(o4), .junkOut(j4));

  function automatic logic [7:0] refShift(logic [7:0] x, int amt, bit left, int w);
    logic [7:0] r = '0;
    for (int b = 0; b < w; b++) begin
      int src;
      src = left ? b - amt : b + amt;
      if (src >= 0 && src < w) r[b] = x[src];
    end
    return r;
  endfunction

  function automatic logic [7:0] mirror(logic [7:0] x, int w);
    logic [7:0] r = '0;
    for (int b = 0; b < w; b++) r[b] = x[w-1-b];
    return r;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic apply8(logic [7:0] x, int amt, bit left);
    @(posedge clk);
    d8 = x; a8 = A8'(amt); l8 = left;
    @(negedge clk);
  endtask

  task automatic apply4(logic [3:0] x, int amt, bit left);
    @(posedge clk);
    d4 = x; a4 = A4'(amt); l4 = left;
    @(negedge clk);
  endtask

  task automatic full8(logic [7:0] x, int amt, bit left);
    apply8(x, amt, left);
    if (left) check("R2 left8", 64'(o8), 64'(refShift(x, amt, 1'b1, W8)));
    else      check("R1 right8", 64'(o8), 64'(refShift(x, amt, 1'b0, W8)));
    if (amt == 0) check("R3 pass8", 64'(o8), 64'(x));
    check("R4 ones8", 64'($countones(o8) <= $countones(x)), 64'd1);
    check("R6 junk8", 64'(j8[7:0]), left ? 64'hff : 64'h0);
  endtask

  task automatic full4(logic [3:0] x, int amt, bit left);
    apply4(x, amt, left);
    if (left) check("R2 left4", 64'(o4), 64'(refShift({4'b0, x}, amt, 1'b1, W4)));
    else      check("R1 right4", 64'(o4), 64'(refShift({4'b0, x}, amt, 1'b0, W4)));
    if (amt == 0) check("R3 pass4", 64'(o4), 64'(x));
    check("R6 junk4", 64'(j4[3:0]), left ? 64'hf : 64'h0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R5: zero word, every amount and direction
    for (int lf = 0; lf < 2; lf++)
      for (int s = 0; s < 8; s++) begin
        apply8(8'h00, s, bit'(lf));
        check("R5 zero8", 64'(o8), 64'h0);
      end
    // R4: all-ones never wraps
    for (int s = 0; s < 8; s++) begin
      apply8(8'hff, s, 1'b0);
      check("R4 ones-right", 64'($countones(o8)), 64'(8 - s));
      apply8(8'hff, s, 1'b1);
      check("R4 ones-left", 64'($countones(o8)), 64'(8 - s));
    end
    // R7: named-bit directed table, 4-bit build
    for (int v = 0; v < 16; v++) begin
      logic [3:0] m;
      m = 4'(v);
      apply4(m, 1, 1'b0); check("R7 r1", 64'(o4), 64'({1'b0, m[3], m[2], m[1]}));
      apply4(m, 2, 1'b0); check("R7 r2", 64'(o4), 64'({2'b0, m[3], m[2]}));
      apply4(m, 3, 1'b0); check("R7 r3", 64'(o4), 64'({3'b0, m[3]}));
      apply4(m, 1, 1'b1); check("R7 l1", 64'(o4), 64'({m[2], m[1], m[0], 1'b0}));
      apply4(m, 2, 1'b1); check("R7 l2", 64'(o4), 64'({m[1], m[0], 2'b0}));
      apply4(m, 3, 1'b1); check("R7 l3", 64'(o4), 64'({m[0], 3'b0}));
    end
    // exhaustive sweeps, R1 R2 R3 R6
    for (int v = 0; v < 16; v++)
      for (int s = 0; s < 4; s++)
        for (int lf = 0; lf < 2; lf++) full4(4'(v), s, bit'(lf));
    for (int v = 0; v < 256; v++)
      for (int s = 0; s < 8; s++)
        for (int lf = 0; lf < 2; lf++) full8(8'(v), s, bit'(lf));
    // R8: random words against mirrored right shifts
    for (int k = 0; k < 300; k++) begin
      logic [7:0] x, leftRes;
      int s;
      x = 8'($urandom);
      s = int'($urandom % 8);
      apply8(x, s, 1'b1);
      leftRes = o8;
      apply8(mirror(x, W8), s, 1'b0);
      check("R8 mirror", 64'(mirror(o8, W8)), 64'(leftRes));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule